// File: doc/BRIEF.md
# Oversampled Serial Receiver with Line Status

This block receives asynchronous serial characters. It samples the line on a sample-enable pulse that arrives sixteen times per bit. The character format is set at run time: five to eight data bits, one or two stop bits, and optional parity in one of four modes. Each completed character is written to a sixteen-entry receive queue. Three tag bits travel with the character through the queue: a parity fault, a framing fault and a break.

A consumer reads the head of the queue through `rd_data` and the head tag outputs, and pops the entry with `rd_pop`. Sticky status flags report queue overrun and the faults of the character at the head. A combined error flag says that a faulty character has entered the queue. Pulsing `stat_rd` models a read of the status word and clears the sticky flags. After a bad stop bit, the receiver treats the low level as the start of the next character. After a break, it waits for the line to return high.

Top module: `serial_rx_status`

## Requirements
- R1: `word_len` selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data arrives least significant bit first and appears right-aligned on `rd_data`, with the unused upper bits at zero.
- R2: A low level seen on a sample pulse starts a character only if the line is still low on the eighth sample pulse after it. A shorter low pulse produces no character.
- R3: When `par_en` is 1, one parity bit follows the data. `par_mode` selects the expected parity bit: 00 odd, 01 even, 10 always 1, 11 always 0. A mismatch sets the parity tag of that character.
- R4: A first stop bit sampled low sets the framing tag of the character. That low level is then taken as a validated start bit, and the next character's data bits are sampled from it.
- R5: When `two_stop` is 1, a second stop bit is also sampled. If it is low, the character gets the framing tag and the receiver resynchronises as in R4.
- R6: If the start bit, the data bits, the parity bit and the first stop bit are all low, one character of value 0 is queued with the break and framing tags set. No further character is produced until the line has been seen high.
- R7: If a character completes while the queue holds 16 entries, `ovr_flag` sets, the queued entries stay unchanged and the new character is dropped.
- R8: `par_flag`, `frm_flag` and `brk_flag` set when a character carrying that tag becomes the head of the queue. A `stat_rd` pulse clears them and `ovr_flag`. The head tag outputs keep following the head character.
- R9: `fifo_err_flag` sets when a character with any tag enters the queue. A `stat_rd` pulse clears it only if no tagged character remains in the queue.
- R10: `data_ready` is 1 exactly while the queue is not empty. `rd_pop` removes the head entry.
- R11: A `flush` pulse empties the queue, and characters written afterwards are read back in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | Sample pulse, 16 per bit time |
| rxd | input | 1 | Serial line, high when idle |
| word_len | input | 2 | Data bit count select |
| two_stop | input | 1 | Check a second stop bit |
| par_en | input | 1 | Parity bit present |
| par_mode | input | 2 | Parity mode select |
| rd_pop | input | 1 | Remove the head entry |
| stat_rd | input | 1 | Status read pulse, clears sticky flags |
| flush | input | 1 | Empty the queue |
| rd_data | output | 8 | Head character |
| head_par_err | output | 1 | Parity tag of the head |
| head_frm_err | output | 1 | Framing tag of the head |
| head_brk | output | 1 | Break tag of the head |
| data_ready | output | 1 | Queue not empty |
| ovr_flag | output | 1 | Sticky overrun |
| par_flag | output | 1 | Sticky parity fault |
| frm_flag | output | 1 | Sticky framing fault |
| brk_flag | output | 1 | Sticky break |
| fifo_err_flag | output | 1 | A tagged character has entered the queue |

## Verification
The assertions assume two things about the inputs. First, the format inputs stay constant while a character is being received. Second, `rd_pop` is pulsed only while the queue holds data, so that a pop and a dropped character are never confused. The stimulus changes the format only after the line has been idle for whole bit times. Its reader pops only after it has seen `data_ready` high, and it holds each pop for one cycle. The serial waveform is driven 32 clocks per bit against a sample pulse on every second clock. Every mid-bit sample therefore lands well inside its bit, and the resynchronisation cases stay aligned.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    typedef struct packed {
        logic par;
        logic frm;
        logic brk;
    } tag_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP1 = 3'd4,
        ST_STOP2 = 3'd5,
        ST_PARK  = 3'd6
    } rx_state_e;

    localparam logic [1:0] PM_ODD  = 2'b00;
    localparam logic [1:0] PM_EVEN = 2'b01;
    localparam logic [1:0] PM_ONE  = 2'b10;
    localparam logic [1:0] PM_ZERO = 2'b11;

endpackage

// File: rtl/rxs_framer.sv
module rxs_framer
    import rxs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic [1:0]        word_len,
    input  logic              two_stop,
    input  logic              par_en,
    input  logic [1:0]        par_mode,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output tag_t              push_tag
);
    localparam int CNT_W = $clog2(OSR);
    localparam int BIT_W = $clog2(DATA_W);
    localparam int MID   = OSR / 2 - 1;
    localparam int BASE  = DATA_W - 4;

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  nbit;
        logic [DATA_W-1:0] sh;
        logic              zero;
        logic              perr;
        logic              push;
        logic [DATA_W-1:0] odata;
        tag_t              otag;
    } fr_t;

    fr_t r_q, r_d;

    logic [BIT_W-1:0]  last_bit;
    logic [DATA_W-1:0] aligned;
    logic              exp_par;
    logic              mid_hit;
    logic              full_hit;

    always_comb begin
        last_bit = BIT_W'(BASE) + BIT_W'(word_len);
        aligned  = r_q.sh >> (2'd3 - word_len);
        case (par_mode)
            PM_ODD:  exp_par = ~(^aligned);
            PM_EVEN: exp_par = ^aligned;
            PM_ONE:  exp_par = 1'b1;
            default: exp_par = 1'b0;
        endcase
        mid_hit  = tick && (r_q.cnt == CNT_W'(MID));
        full_hit = tick && (r_q.cnt == CNT_W'(OSR - 1));

        r_d      = r_q;
        r_d.push = 1'b0;
        if (tick && !mid_hit && !full_hit) r_d.cnt = r_q.cnt + CNT_W'(1);

        case (r_q.st)
            ST_IDLE: begin
                if (tick && !rxd) begin
                    r_d.st  = ST_START;
                    r_d.cnt = '0;
                end
            end
            ST_START: begin
                if (mid_hit) begin
                    r_d.cnt  = '0;
                    r_d.nbit = '0;
                    r_d.sh   = '0;
                    r_d.zero = 1'b1;
                    r_d.perr = 1'b0;
                    r_d.st   = rxd ? ST_IDLE : ST_DATA;
                end else if (full_hit) begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_DATA: begin
                if (full_hit) begin
                    r_d.cnt  = '0;
                    r_d.sh   = {rxd, r_q.sh[DATA_W-1:1]};
                    r_d.zero = r_q.zero & ~rxd;
                    if (r_q.nbit == last_bit) begin
                        r_d.st = par_en ? ST_PAR : ST_STOP1;
                    end else begin
                        r_d.nbit = r_q.nbit + BIT_W'(1);
                    end
                end else if (mid_hit) begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_PAR: begin
                if (full_hit) begin
                    r_d.cnt  = '0;
                    r_d.perr = (rxd != exp_par);
                    r_d.zero = r_q.zero & ~rxd;
                    r_d.st   = ST_STOP1;
                end else if (mid_hit) begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_STOP1, ST_STOP2: begin
                if (full_hit) begin
                    r_d.cnt = '0;
                    if (!rxd && r_q.zero && r_q.st == ST_STOP1) begin
                        r_d.push  = 1'b1;
                        r_d.odata = '0;
                        r_d.otag  = '{par: 1'b0, frm: 1'b1, brk: 1'b1};
                        r_d.st    = ST_PARK;
                    end else if (!rxd) begin
                        r_d.push  = 1'b1;
                        r_d.odata = aligned;
                        r_d.otag  = '{par: r_q.perr, frm: 1'b1, brk: 1'b0};
                        r_d.nbit  = '0;
                        r_d.sh    = '0;
                        r_d.zero  = 1'b1;
                        r_d.perr  = 1'b0;
                        r_d.st    = ST_DATA;
                    end else if (two_stop && r_q.st == ST_STOP1) begin
                        r_d.st = ST_STOP2;
                    end else begin
                        r_d.push  = 1'b1;
                        r_d.odata = aligned;
                        r_d.otag  = '{par: r_q.perr, frm: 1'b0, brk: 1'b0};
                        r_d.st    = ST_IDLE;
                    end
                end else if (mid_hit) begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_PARK: begin
                if (tick && rxd) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign push      = r_q.push;
    assign push_data = r_q.odata;
    assign push_tag  = r_q.otag;

    // R6
    park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PARK && !rxd) |=> (r_q.st == ST_PARK));

    // R2
    push_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> $past(tick));

endmodule

// File: rtl/rxs_fifo.sv
module rxs_fifo
    import rxs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  tag_t              push_tag,
    input  logic              pop,
    input  logic              flush,
    output logic [DATA_W-1:0] head_data,
    output tag_t              head_tag,
    output logic              empty,
    output logic              drop,
    output logic              err_in,
    output logic              err_any
);
    localparam int PTR_W   = $clog2(DEPTH);
    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int ENTRY_W = DATA_W + 3;

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] ecnt;
    } fq_t;

    fq_t r_q, r_d;
    logic [ENTRY_W-1:0] mem_q [DEPTH];

    logic full, push_ok, pop_ok;

    always_comb begin
        full    = (r_q.cnt == CNT_W'(DEPTH));
        empty   = (r_q.cnt == '0);
        push_ok = push && !full && !flush;
        pop_ok  = pop && !empty && !flush;
        drop    = push && full && !flush;
        err_in  = push_ok && (|push_tag);
        err_any = (r_q.ecnt != '0);
        head_data = mem_q[r_q.rd][ENTRY_W-1:3];
        head_tag  = tag_t'(mem_q[r_q.rd][2:0]);

        r_d = r_q;
        if (flush) begin
            r_d = '0;
        end else begin
            if (push_ok)
                r_d.wr = (r_q.wr == PTR_W'(DEPTH - 1)) ? '0 : r_q.wr + PTR_W'(1);
            if (pop_ok)
                r_d.rd = (r_q.rd == PTR_W'(DEPTH - 1)) ? '0 : r_q.rd + PTR_W'(1);
            r_d.cnt  = r_q.cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
            r_d.ecnt = r_q.ecnt + CNT_W'(err_in) - CNT_W'(pop_ok && (|head_tag));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[r_q.wr] <= {push_data, push_tag};
    end

    // R7
    drop_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !pop) |=> (r_q.cnt == CNT_W'(DEPTH)));

    // R11
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/rxs_status.sv
module rxs_status
    import rxs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stat_rd,
    input  logic flush,
    input  logic pop,
    input  logic nonempty,
    input  tag_t head_tag,
    input  logic drop,
    input  logic err_in,
    input  logic err_any,
    output logic ovr_flag,
    output logic par_flag,
    output logic frm_flag,
    output logic brk_flag,
    output logic fifo_err_flag
);
    typedef struct packed {
        logic ovr;
        logic par;
        logic frm;
        logic brk;
        logic ferr;
        logic seen;
    } st_t;

    st_t r_q, r_d;
    logic head_new;

    always_comb begin
        head_new  = nonempty && !r_q.seen;
        r_d.seen  = nonempty && !pop && !flush;
        r_d.ovr   = (r_q.ovr && !stat_rd) || drop;
        r_d.par   = (r_q.par && !stat_rd) || (head_new && head_tag.par);
        r_d.frm   = (r_q.frm && !stat_rd) || (head_new && head_tag.frm);
        r_d.brk   = (r_q.brk && !stat_rd) || (head_new && head_tag.brk);
        r_d.ferr  = err_in || (r_q.ferr && !(stat_rd && !err_any));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ovr_flag      = r_q.ovr;
    assign par_flag      = r_q.par;
    assign frm_flag      = r_q.frm;
    assign brk_flag      = r_q.brk;
    assign fifo_err_flag = r_q.ferr;

    // R7
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.ovr) |-> $past(drop));

    // R9
    ferr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ferr && err_any) |=> r_q.ferr);

endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
    import rxs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              rxd,
    input  logic [1:0]        word_len,
    input  logic              two_stop,
    input  logic              par_en,
    input  logic [1:0]        par_mode,
    input  logic              rd_pop,
    input  logic              stat_rd,
    input  logic              flush,
    output logic [DATA_W-1:0] rd_data,
    output logic              head_par_err,
    output logic              head_frm_err,
    output logic              head_brk,
    output logic              data_ready,
    output logic              ovr_flag,
    output logic              par_flag,
    output logic              frm_flag,
    output logic              brk_flag,
    output logic              fifo_err_flag
);
    logic              push;
    logic [DATA_W-1:0] push_data;
    tag_t              push_tag;
    tag_t              head_tag;
    logic              empty, drop, err_in, err_any;

    rxs_framer #(.DATA_W(DATA_W), .OSR(OSR)) framer_i (
        .clk(clk), .rst_n(rst_n), .tick(sample_en), .rxd(rxd),
        .word_len(word_len), .two_stop(two_stop), .par_en(par_en),
        .par_mode(par_mode), .push(push), .push_data(push_data),
        .push_tag(push_tag)
    );

    rxs_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .push_tag(push_tag), .pop(rd_pop), .flush(flush),
        .head_data(rd_data), .head_tag(head_tag), .empty(empty),
        .drop(drop), .err_in(err_in), .err_any(err_any)
    );

    rxs_status status_i (
        .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .flush(flush),
        .pop(rd_pop), .nonempty(!empty), .head_tag(head_tag), .drop(drop),
        .err_in(err_in), .err_any(err_any), .ovr_flag(ovr_flag),
        .par_flag(par_flag), .frm_flag(frm_flag), .brk_flag(brk_flag),
        .fifo_err_flag(fifo_err_flag)
    );

    assign data_ready   = !empty;
    assign head_par_err = head_tag.par;
    assign head_frm_err = head_tag.frm;
    assign head_brk     = head_tag.brk;

    // R6
    brk_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && head_brk) |-> (rd_data == '0 && head_frm_err));

endmodule

// File: tb/serial_rx_status_tb_top.sv
`timescale 1ns/1ps
module serial_rx_status_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] word_len = 2'b11;
    logic       two_stop = 1'b0;
    logic       par_en = 1'b0;
    logic [1:0] par_mode = 2'b00;
    logic       rd_pop;
    logic       stat_rd = 1'b0;
    logic       flush = 1'b0;
    logic [7:0] rd_data;
    logic       head_par_err, head_frm_err, head_brk, data_ready;
    logic       ovr_flag, par_flag, frm_flag, brk_flag, fifo_err_flag;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  mon_en = 1'b0;
    bit  ended = 1'b0;
    logic [10:0] exp_q[$];
    string       req_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) tick <= ~tick;

    serial_rx_status dut_i (
        .clk(clk), .rst_n(rst_n), .sample_en(tick), .rxd(rxd),
        .word_len(word_len), .two_stop(two_stop), .par_en(par_en),
        .par_mode(par_mode), .rd_pop(rd_pop), .stat_rd(stat_rd),
        .flush(flush), .rd_data(rd_data), .head_par_err(head_par_err),
        .head_frm_err(head_frm_err), .head_brk(head_brk),
        .data_ready(data_ready), .ovr_flag(ovr_flag), .par_flag(par_flag),
        .frm_flag(frm_flag), .brk_flag(brk_flag),
        .fifo_err_flag(fifo_err_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic int nbits();
        return 5 + int'(word_len);
    endfunction

    function automatic logic [7:0] wmask();
        return 8'hFF >> (8 - nbits());
    endfunction

    function automatic logic par_of(input logic [7:0] d);
        logic x;
        x = ^(d & wmask());
        case (par_mode)
            2'b00:   return ~x;
            2'b01:   return x;
            2'b10:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic expect_item(input logic [7:0] d, input logic p, input logic f,
                               input logic b, input string req);
        exp_q.push_back({d & wmask(), p, f, b});
        req_q.push_back(req);
    endtask

    task automatic drive_bit(input logic v);
        rxd = v;
        repeat (32) @(negedge clk);
    endtask

    task automatic send_body(input logic [7:0] d, input bit bad_par,
                             input bit bad_stop, input bit bad_stop2);
        for (int i = 0; i < nbits(); i++) drive_bit(d[i]);
        if (par_en) drive_bit(par_of(d) ^ bad_par);
        drive_bit(!bad_stop);
        if (two_stop && !bad_stop) drive_bit(!bad_stop2);
        rxd = 1'b1;
    endtask

    task automatic send_char(input logic [7:0] d, input bit bad_par,
                             input bit bad_stop, input bit bad_stop2);
        drive_bit(1'b0);
        send_body(d, bad_par, bad_stop, bad_stop2);
    endtask

    task automatic pulse_rd();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic drain();
        mon_en = 1'b1;
        for (int i = 0; i < 20000 && (exp_q.size() != 0 || data_ready); i++)
            @(negedge clk);
        repeat (4) @(negedge clk);
        mon_en = 1'b0;
        chk("R10 queue drained", exp_q.size(), 0);
    endtask

    // scoreboard monitor: pops and compares the head as it appears
    initial begin
        rd_pop = 1'b0;
        forever begin
            @(negedge clk);
            if (rd_pop) begin
                rd_pop = 1'b0;
            end else if (mon_en && data_ready) begin
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R10 unexpected entry: actual %0h expected none",
                             {rd_data, head_par_err, head_frm_err, head_brk});
                end else begin
                    logic [10:0] e;
                    string r;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    if ({rd_data, head_par_err, head_frm_err, head_brk} !== e) begin
                        n_bad++;
                        $display("FAIL %s: actual %0h expected %0h", r,
                                 {rd_data, head_par_err, head_frm_err, head_brk}, e);
                    end
                end
                rd_pop = 1'b1;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // reset state
        chk("R10 reset data_ready", data_ready, 0);
        chk("R8 reset flags", {ovr_flag, par_flag, frm_flag, brk_flag, fifo_err_flag}, 0);

        // R1 word lengths, no parity
        word_len = 2'b11;
        expect_item(8'hA5, 0, 0, 0, "R1 8-bit");  send_char(8'hA5, 0, 0, 0);
        chk("R10 data_ready after char", data_ready, 1);
        expect_item(8'h3C, 0, 0, 0, "R1 8-bit"); send_char(8'h3C, 0, 0, 0);
        drain();
        for (int w = 0; w < 3; w++) begin
            word_len = w[1:0];
            expect_item(8'hFF, 0, 0, 0, "R1 short word");  send_char(8'hFF, 0, 0, 0);
            expect_item(8'h35, 0, 0, 0, "R1 short word");  send_char(8'h35, 0, 0, 0);
        end
        drain();
        word_len = 2'b11;

        // R3 parity modes, good and bad parity
        par_en = 1'b1;
        for (int m = 0; m < 4; m++) begin
            par_mode = m[1:0];
            expect_item(8'h96, 0, 0, 0, "R3 good parity"); send_char(8'h96, 0, 0, 0);
            expect_item(8'h17, 1, 0, 0, "R3 bad parity");  send_char(8'h17, 1, 0, 0);
        end
        word_len = 2'b10;
        par_mode = 2'b00;
        expect_item(8'h41, 1, 0, 0, "R3 7-bit bad parity"); send_char(8'h41, 1, 0, 0);
        drain();
        chk("R8 par_flag set by head", par_flag, 1);
        pulse_rd();
        chk("R8 par_flag cleared", par_flag, 0);
        chk("R9 fifo_err cleared with clean queue", fifo_err_flag, 0);
        par_en = 1'b0;
        word_len = 2'b11;

        // R2 short low pulse rejected
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (128) @(negedge clk);
        chk("R2 glitch ignored", data_ready, 0);
        expect_item(8'h5E, 0, 0, 0, "R2 char after glitch"); send_char(8'h5E, 0, 0, 0);
        drain();

        // R4 framing error and resync on the low stop bit
        expect_item(8'h5A, 0, 1, 0, "R4 framing tag");  send_char(8'h5A, 0, 1, 0);
        expect_item(8'hC3, 0, 0, 0, "R4 resync char");  send_body(8'hC3, 0, 0, 0);
        drain();
        chk("R8 frm_flag set", frm_flag, 1);
        pulse_rd();
        chk("R8 frm_flag cleared", frm_flag, 0);

        // R5 two stop bits
        two_stop = 1'b1;
        expect_item(8'h81, 0, 0, 0, "R5 clean two stop");  send_char(8'h81, 0, 0, 0);
        expect_item(8'h66, 0, 1, 0, "R5 bad second stop"); send_char(8'h66, 0, 0, 1);
        expect_item(8'h29, 0, 0, 0, "R5 resync char");     send_body(8'h29, 0, 0, 0);
        drain();
        two_stop = 1'b0;
        pulse_rd();

        // R6 break
        rxd = 1'b0;
        repeat (12 * 32) @(negedge clk);
        chk("R6 one break entry", data_ready, 1);
        chk("R6 break entry value", {rd_data, head_par_err, head_frm_err, head_brk}, 11'h003);
        chk("R6 brk_flag", brk_flag, 1);
        expect_item(8'h00, 0, 1, 1, "R6 break entry");
        rxd = 1'b1;
        repeat (64) @(negedge clk);
        expect_item(8'h7E, 0, 0, 0, "R6 char after break"); send_char(8'h7E, 0, 0, 0);
        drain();
        pulse_rd();
        chk("R8 brk_flag cleared", brk_flag, 0);

        // R8 / R9 sticky flags against the head
        par_en = 1'b1;
        par_mode = 2'b01;
        expect_item(8'h11, 1, 0, 0, "R3 bad parity"); send_char(8'h11, 1, 0, 0);
        chk("R8 head tag", head_par_err, 1);
        chk("R8 par_flag from head", par_flag, 1);
        pulse_rd();
        chk("R8 par_flag read clear", par_flag, 0);
        chk("R8 head tag stays", head_par_err, 1);
        expect_item(8'h22, 0, 0, 0, "R3 good parity"); send_char(8'h22, 0, 0, 0);
        chk("R9 fifo_err set", fifo_err_flag, 1);
        pulse_rd();
        chk("R9 fifo_err kept while tagged entry queued", fifo_err_flag, 1);
        drain();
        pulse_rd();
        chk("R9 fifo_err cleared after drain", fifo_err_flag, 0);
        chk("R8 par_flag after drain", par_flag, 0);
        par_en = 1'b0;

        // R7 overrun
        for (int i = 0; i < 17; i++) begin
            if (i < 16) expect_item(8'h10 + 8'(i), 0, 0, 0, "R7 kept entry");
            send_char(8'h10 + 8'(i), 0, 0, 0);
        end
        chk("R7 ovr_flag", ovr_flag, 1);
        chk("R7 head unchanged", rd_data, 8'h10);
        drain();
        pulse_rd();
        chk("R8 ovr_flag cleared", ovr_flag, 0);

        // R11 flush
        send_char(8'hE1, 0, 0, 0);
        send_char(8'hE2, 0, 0, 0);
        chk("R10 data_ready before flush", data_ready, 1);
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        chk("R11 flush empties", data_ready, 0);
        expect_item(8'h9C, 0, 0, 0, "R11 after flush"); send_char(8'h9C, 0, 0, 0);
        expect_item(8'h4D, 0, 0, 0, "R11 after flush"); send_char(8'h4D, 0, 0, 0);
        drain();

        finish_run();
    end

endmodule